// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-facing protocol engine of a two-wire serial memory. A fast system clock samples the raw clock and data lines. The engine finds start and stop conditions and decodes the device-select byte against a three-bit board strap. It takes in a 16-bit memory address and acknowledges every byte it accepts. In read transfers it shifts data bytes back out. The SDA output is an open-drain style pull-down enable.

The engine keeps the memory pointer, so it supports three kinds of read: current-address, random (a dummy write followed by a repeated start) and sequential. Bytes received in a write go to a downstream page-write controller, together with the start address and an end-of-write pulse at the stop. While that controller reports an internal write in progress, the engine does not acknowledge its select byte, so a master can poll for completion. When the controller finishes, it reports the last location written, and the pointer moves to the next location.

Top module: `tw_slave_engine`

## Requirements
- R1: A start condition (SDA falling while SCL is high) in any state abandons the current transfer and makes the next eight bits a device-select byte; an address byte cut short by a start does not change the pointer.
- R2: A select byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal `strap_id`; bit 0 set means read, clear means write. A mismatching select is not acknowledged, and the engine stays silent until the next start.
- R3: For every accepted byte the engine asserts `sda_oe` (pulling SDA low) from the falling SCL edge after the eighth bit to the falling edge that closes the ninth clock; `sda_oe` changes only while SCL is low.
- R4: While `wr_busy` is high, a matching select byte is not acknowledged; once it is low, the same select is acknowledged.
- R5: In a write, the two bytes after the select form the address, high byte first. Each following data byte is acknowledged and presented for one cycle on `wr_valid` with `wr_data`, and with `wr_addr` holding that address, in arrival order.
- R6: A stop after at least one data byte gives a one-cycle `wr_stop` pulse; a stop after a transfer without data bytes gives none.
- R7: A read select with no address phase returns the byte at the pointer; each byte sent advances the pointer by one, and the pointer is 0 after reset.
- R8: A write select and two address bytes, followed by a repeated start and a read select, return the byte at the supplied address.
- R9: After each master ACK in a read the next byte follows from the next address, with 0xFFFF followed by 0x0000; after a master NACK, SDA is released and no further bit is driven.
- R10: A one-cycle `upd_valid` sets the pointer to `upd_addr` plus one, so a later current-address read continues after the last written location.
- R11: During reset and directly after it, `sda_oe`, `wr_valid` and `wr_stop` are low and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_id | input | 3 | Board strap the select byte must match |
| wr_busy | input | 1 | Page-write controller is programming |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 16 | Start address of the current write |
| wr_data | output | 8 | Received write byte |
| wr_stop | output | 1 | One-cycle pulse: write transfer closed by stop |
| rd_addr | output | 16 | Current pointer, used as the read address |
| rd_data | input | 8 | Byte at `rd_addr`, valid in the same cycle |
| upd_valid | input | 1 | Controller reports the last written location |
| upd_addr | input | 16 | Last location written by the controller |

## Verification
The assertions assume the master holds SCL low for longer than the synchronizer and edge-detect latency (at least four system clocks), and moves SDA only while SCL is low, except at start and stop. They also assume `upd_valid` arrives as an isolated pulse while the bus is idle. The master in the bench uses quarter periods of eight system clocks. It changes SDA a full quarter after each SCL fall, so the engine's own SDA changes and the master's never meet an SCL high phase. It pulses `upd_valid` and toggles `wr_busy` only between transfers.

// File: rtl/tw_pkg.sv
// Shared constants and state types of the two-wire slave engine.
// Assumes byte-wide transfers and a two-byte memory address.
package tw_pkg;
    localparam int BYTE_W    = 8;
    localparam int PTR_W     = 2 * BYTE_W;
    localparam int STRAP_W   = 3;
    localparam int BITCNT_W  = $clog2(BYTE_W);
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MWAIT
    } xfer_st_t;

    typedef enum logic [1:0] {
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } rx_ph_t;
endpackage

// File: rtl/tw_line_sync.sv
// Synchronizes one raw bus line into the system clock domain.
// Assumes the idle bus level is high, so the chain resets to ones.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // single flop, no metastability margin
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_chain
            // shift the line through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
// Turns synchronized SCL/SDA into one-cycle bus events:
// SCL edges, start and stop conditions, and the data bit level.
// Assumes both inputs have passed the same synchronizer depth.
module tw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic scl_d;
    logic sda_d;

    // keep the previous synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_bit   = sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
// Memory pointer: loaded from the address phase, stepped after each
// byte sent, and set past the last location the write controller reports.
// Wrap from the top address to zero comes from the counter width.
module tw_addr_ptr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         inc_en,
    input  logic         upd_en,
    input  logic [W-1:0] upd_val,
    output logic [W-1:0] ptr
);
    // controller report wins, then address load, then step
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (upd_en)  ptr <= upd_val + W'(1);
        else if (load_en) ptr <= load_val;
        else if (inc_en)  ptr <= ptr + W'(1);
    end
endmodule

// File: rtl/tw_xfer_fsm.sv
// Bit and byte level transfer engine. Shifts in select, address and
// data bytes on SCL rises, drives ACK and read bits right after SCL
// falls, and samples the master ACK on the ninth rise of a read byte.
// Assumes the event strobes come from tw_cond_detect and rd_data
// follows rd_addr within the same cycle.
module tw_xfer_fsm
    import tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_bit,
    input  logic [STRAP_W-1:0] strap_id,
    input  logic               wr_busy,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wr_valid,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_stop,
    output logic               ptr_load,
    output logic [PTR_W-1:0]   ptr_load_val,
    output logic               ptr_inc
);
    xfer_st_t            st;
    rx_ph_t              ph;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [BYTE_W-1:0]   hi_q;
    logic [PTR_W-1:0]    base_q;
    logic                got_byte;
    logic                tx_next;
    logic                data_seen;
    logic                sel_match;

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    // select byte decode: type code, strap, and controller idle
    assign sel_match = (rx_sh[BYTE_W-1 -: 4] == DEV_TYPE)
                    && (rx_sh[STRAP_W:1] == strap_id)
                    && !wr_busy;

    // main transfer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_SEL;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            hi_q      <= '0;
            base_q    <= '0;
            got_byte  <= 1'b0;
            tx_next   <= 1'b0;
            data_seen <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_data   <= '0;
            wr_stop   <= 1'b0;
            ptr_load  <= 1'b0;
            ptr_inc   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            wr_stop  <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            if (start_det) begin
                st        <= ST_RX;
                ph        <= PH_SEL;
                cnt       <= '0;
                got_byte  <= 1'b0;
                data_seen <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                st        <= ST_IDLE;
                sda_oe    <= 1'b0;
                wr_stop   <= data_seen;
                data_seen <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_bit};
                            cnt   <= cnt + BITCNT_W'(1);
                            if (cnt == LAST_BIT) got_byte <= 1'b1;
                        end else if (scl_fall && got_byte) begin
                            got_byte <= 1'b0;
                            tx_next  <= 1'b0;
                            case (ph)
                                PH_SEL: begin
                                    if (sel_match) begin
                                        sda_oe  <= 1'b1;
                                        st      <= ST_ACK;
                                        tx_next <= rx_sh[0];
                                        ph      <= PH_AHI;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_AHI: begin
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    hi_q   <= rx_sh;
                                    ph     <= PH_ALO;
                                end
                                PH_ALO: begin
                                    sda_oe   <= 1'b1;
                                    st       <= ST_ACK;
                                    base_q   <= {hi_q, rx_sh};
                                    ptr_load <= 1'b1;
                                    ph       <= PH_DATA;
                                end
                                default: begin
                                    sda_oe    <= 1'b1;
                                    st        <= ST_ACK;
                                    wr_valid  <= 1'b1;
                                    wr_data   <= rx_sh;
                                    data_seen <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (tx_next) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            cnt <= cnt + BITCNT_W'(1);
                            if (cnt == LAST_BIT) begin
                                sda_oe  <= 1'b0;
                                ptr_inc <= 1'b1;
                                st      <= ST_MACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) st <= sda_bit ? ST_IDLE : ST_MWAIT;
                    end
                    ST_MWAIT: begin
                        if (scl_fall) begin
                            cnt    <= '0;
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            st     <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_addr      = base_q;
    assign ptr_load_val = base_q;
endmodule

// File: rtl/tw_slave_engine.sv
// Top of the two-wire slave protocol engine: line synchronizers,
// bus event detection, transfer state machine and memory pointer.
// Assumes the system clock runs well above the SCL rate.
module tw_slave_engine
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_id,
    input  logic               wr_busy,
    output logic               wr_valid,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_stop,
    output logic [PTR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    input  logic               upd_valid,
    input  logic [PTR_W-1:0]   upd_addr
);
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic ptr_load, ptr_inc;
    logic [PTR_W-1:0] ptr_load_val;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
    );

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
    );

    tw_cond_detect u_detect (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_bit(sda_bit)
    );

    tw_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_bit(sda_bit),
        .strap_id(strap_id), .wr_busy(wr_busy),
        .rd_data(rd_data),
        .sda_oe(sda_oe),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_stop(wr_stop),
        .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .ptr_inc(ptr_inc)
    );

    tw_addr_ptr #(.W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load_en(ptr_load), .load_val(ptr_load_val),
        .inc_en(ptr_inc),
        .upd_en(upd_valid), .upd_val(upd_addr),
        .ptr(rd_addr)
    );
endmodule

// File: rtl/tw_slave_checker.sv
// Protocol properties of the slave engine, bound to its top.
// Assumes SCL low phases are longer than the input detection latency.
module tw_slave_checker
    import tw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             wr_valid,
    input logic             wr_stop,
    input logic             upd_valid,
    input logic [PTR_W-1:0] upd_addr,
    input logic [PTR_W-1:0] ptr
);
    // R3: the pull-down changes only while the raw clock line is low
    a_r3_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

    // R5: each received write byte is a single-cycle strobe
    a_r5_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R6: end-of-write is a single-cycle pulse
    a_r6_stop_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> !wr_stop);

    // R6: end-of-write never coincides with a data strobe
    a_r6_stop_apart_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_stop);

    // R10: a controller report lands the pointer one past it
    a_r10_ptr_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ptr == PTR_W'($past(upd_addr) + PTR_W'(1))));
endmodule

bind tw_slave_engine tw_slave_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_stop(wr_stop),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .ptr(rd_addr)
);

// File: tb/tw_slave_engine_bench.sv
module tw_slave_engine_bench;
    localparam int Q  = 8;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m, sda_m;
    logic        sda_bus;
    logic        sda_oe;
    logic [2:0]  strap_id = 3'b101;
    logic        wr_busy;
    logic        wr_valid, wr_stop;
    logic [15:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        upd_valid;
    logic [15:0] upd_addr;
    logic        done = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    typedef struct packed {
        logic        is_stop;
        logic [15:0] addr;
        logic [7:0]  data;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] + (a[15:8] * 8'd3);
        return t ^ 8'h5A;
    endfunction

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = memf(rd_addr);

    tw_slave_engine u_tw_slave_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_id(strap_id), .wr_busy(wr_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_stop(wr_stop), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_valid(upd_valid), .upd_addr(upd_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b0; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b1; quarter();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        acked = (sda_bus == 1'b0);
        quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; quarter();
            scl_m = 1'b1; quarter();
            b[i] = sda_bus;
            quarter();
            scl_m = 1'b0; quarter();
        end
        sda_m = !master_ack; quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
    endtask

    // driver side of the scoreboard
    task automatic push_data(input logic [15:0] a, input logic [7:0] d);
        exp_q.push_back('{is_stop: 1'b0, addr: a, data: d});
    endtask

    task automatic push_stop();
        exp_q.push_back('{is_stop: 1'b1, addr: 16'h0, data: 8'h0});
    endtask

    // monitor side: pop and compare every write-side event (R5, R6)
    always @(negedge clk) begin
        if (rst_n && (wr_valid || wr_stop)) begin
            if (exp_q.size() == 0) begin
                check("R6", "unexpected write event", {30'd0, wr_stop, wr_valid}, 32'd0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check("R6", "event kind is stop", {31'd0, wr_stop}, {31'd0, it.is_stop});
                if (!it.is_stop) begin
                    check("R5", "write address", {16'd0, wr_addr}, {16'd0, it.addr});
                    check("R5", "write data", {24'd0, wr_data}, {24'd0, it.data});
                end
            end
        end
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        wr_busy = 1'b0; upd_valid = 1'b0; upd_addr = 16'h0;
        repeat (5) @(negedge clk);
        // R11: quiet outputs under reset
        check("R11", "sda_oe in reset", {31'd0, sda_oe}, 32'd0);
        check("R11", "wr_valid in reset", {31'd0, wr_valid}, 32'd0);
        check("R11", "wr_stop in reset", {31'd0, wr_stop}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "pointer after reset", {16'd0, rd_addr}, 32'd0);
        check("R11", "sda_oe after reset", {31'd0, sda_oe}, 32'd0);

        // R7: current-address reads from reset pointer
        bus_start();
        put_byte(8'hAB, ack);
        check("R3", "read select ack", {31'd0, ack}, 32'd1);
        get_byte(1'b0, b);
        check("R7", "current read at 0", {24'd0, b}, {24'd0, memf(16'h0000)});
        bus_stop();
        bus_start();
        put_byte(8'hAB, ack);
        get_byte(1'b0, b);
        check("R7", "current read at 1", {24'd0, b}, {24'd0, memf(16'h0001)});
        bus_stop();

        // R2: wrong strap and wrong type code are ignored
        bus_start();
        put_byte(8'hA7, ack);
        check("R2", "wrong strap not acked", {31'd0, ack}, 32'd0);
        get_byte(1'b0, b);
        check("R2", "silent after mismatch", {24'd0, b}, 32'hFF);
        bus_stop();
        bus_start();
        put_byte(8'hBA, ack);
        check("R2", "wrong type not acked", {31'd0, ack}, 32'd0);
        bus_stop();

        // R5, R6: page write of three bytes
        push_data(16'h1234, 8'hA5);
        push_data(16'h1234, 8'h5A);
        push_data(16'h1234, 8'h0F);
        push_stop();
        bus_start();
        put_byte(8'hAA, ack);
        check("R3", "write select ack", {31'd0, ack}, 32'd1);
        put_byte(8'h12, ack);
        check("R3", "high address ack", {31'd0, ack}, 32'd1);
        put_byte(8'h34, ack);
        check("R3", "low address ack", {31'd0, ack}, 32'd1);
        put_byte(8'hA5, ack);
        check("R5", "data byte ack", {31'd0, ack}, 32'd1);
        put_byte(8'h5A, ack);
        put_byte(8'h0F, ack);
        check("R5", "last data byte ack", {31'd0, ack}, 32'd1);
        bus_stop();
        quarter();
        check("R6", "all write events seen", exp_q.size(), 32'd0);

        // R8, R1: random read via repeated start (no wr_stop expected)
        bus_start();
        put_byte(8'hAA, ack);
        put_byte(8'hAB, ack);
        put_byte(8'hCD, ack);
        bus_start();
        put_byte(8'hAB, ack);
        check("R1", "select after repeated start", {31'd0, ack}, 32'd1);
        get_byte(1'b0, b);
        check("R8", "random read at ABCD", {24'd0, b}, {24'd0, memf(16'hABCD)});
        bus_stop();

        // R9: sequential read across the top of the array
        bus_start();
        put_byte(8'hAA, ack);
        put_byte(8'hFF, ack);
        put_byte(8'hFE, ack);
        bus_start();
        put_byte(8'hAB, ack);
        get_byte(1'b1, b);
        check("R9", "seq byte FFFE", {24'd0, b}, {24'd0, memf(16'hFFFE)});
        get_byte(1'b1, b);
        check("R9", "seq byte FFFF", {24'd0, b}, {24'd0, memf(16'hFFFF)});
        get_byte(1'b1, b);
        check("R9", "seq wrap to 0000", {24'd0, b}, {24'd0, memf(16'h0000)});
        get_byte(1'b0, b);
        check("R9", "seq byte 0001", {24'd0, b}, {24'd0, memf(16'h0001)});
        check("R9", "released after nack", {31'd0, sda_oe}, 32'd0);
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        check("R9", "no bit driven after nack", {31'd0, sda_bus}, 32'd1);
        scl_m = 1'b0; quarter();
        bus_stop();

        // R7: current read continues after sequential read
        bus_start();
        put_byte(8'hAB, ack);
        get_byte(1'b0, b);
        check("R7", "current read at 0002", {24'd0, b}, {24'd0, memf(16'h0002)});
        bus_stop();

        // R4: busy controller blocks selection
        wr_busy = 1'b1;
        bus_start();
        put_byte(8'hAA, ack);
        check("R4", "select nacked while busy", {31'd0, ack}, 32'd0);
        bus_stop();
        wr_busy = 1'b0;
        bus_start();
        put_byte(8'hAA, ack);
        check("R4", "select acked when idle", {31'd0, ack}, 32'd1);
        bus_stop();
        quarter();
        check("R6", "no stop pulse without data", exp_q.size(), 32'd0);

        // R10: controller report moves the pointer
        upd_addr = 16'h2040;
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
        check("R10", "pointer after report", {16'd0, rd_addr}, 32'h2041);
        bus_start();
        put_byte(8'hAB, ack);
        get_byte(1'b0, b);
        check("R10", "read after report", {24'd0, b}, {24'd0, memf(16'h2041)});
        bus_stop();

        // R1: start in the middle of an address byte aborts it
        bus_start();
        put_byte(8'hAA, ack);
        put_byte(8'h55, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        put_byte(8'hAB, ack);
        check("R1", "select after abort acked", {31'd0, ack}, 32'd1);
        get_byte(1'b0, b);
        check("R1", "pointer untouched by abort", {24'd0, b}, {24'd0, memf(16'h2042)});
        bus_stop();
        quarter();
        check("R6", "scoreboard empty at end", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule